// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short record of how transmitted frames ended. The transmit engine signals each completion with collision, underrun and jabber indications, and says whether the frame asked to be reported even on success. Each recorded completion becomes one status byte in a small store. The host sees the oldest byte on a read port and discards it with a pop strobe. A completion-pending output stays high while any byte is waiting.

The block also enforces the transmit fault policy. A jabber or underrun completion turns the transmitter off and holds it off. A host data write into a full transmit data buffer raises a sticky overrun flag and a one-cycle adapter-failure pulse, and also turns the transmitter off. Only a transmit reset or a global reset clears these conditions. After a transmit reset the transmitter stays off until it is explicitly enabled again.

Top module: `tx_stat_stack`

## Requirements
- R1: Status byte fields: bit 7 = completion recorded (always 1 in a stored entry), bit 6 = success report requested, bit 5 = jabber, bit 4 = underrun, bit 3 = maximum collisions, bit 2 = an entry was lost. Bits 1..0 always read 0.
- R2: A completion with no error pushes an entry only if the frame asked for a success report. That entry reads 0xC0. Without the request nothing is stored.
- R3: A completion with any error (jabber, underrun or maximum collisions) always pushes an entry. A completion with only maximum collisions does not disable the transmitter.
- R4: A pop strobe removes the top entry. Entries leave in arrival order. A pop and a push in the same cycle both take effect.
- R5: The store holds DEPTH entries (default 4). A completion that arrives while the store is full, with no pop in the same cycle, is dropped, and bit 2 is set in the current top entry.
- R6: tx_cpl_o is 1 exactly when the store holds an entry. An empty store reads 0x00. A pop on an empty store has no effect.
- R7: A jabber or underrun completion clears tx_en_o on the next cycle. tx_enable_i has no effect until a transmit reset.
- R8: A data write while the data buffer is full sets tx_ovr_o and clears tx_en_o. adapter_fail_o pulses for exactly one cycle when tx_ovr_o first sets.
- R9: tx_reset_i empties the store, clears tx_ovr_o and the fault lock, and leaves tx_en_o at 0 until tx_enable_i is asserted.
- R10: After rst_ni the store is empty, stat_o is 0x00, and tx_en_o, tx_ovr_o and adapter_fail_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous global reset |
| cpl_valid_i | input | 1 | A frame completion is reported this cycle |
| cpl_req_i | input | 1 | The frame asked for a success report |
| cpl_jabber_i | input | 1 | The frame ended with a jabber error |
| cpl_underrun_i | input | 1 | The frame ended with an underrun |
| cpl_maxcoll_i | input | 1 | The frame hit the maximum collision count |
| pop_i | input | 1 | Host write to the status port: pop the top entry |
| tx_reset_i | input | 1 | Transmit reset |
| tx_enable_i | input | 1 | Transmit enable command |
| data_wr_i | input | 1 | Host writes a transmit data word |
| data_full_i | input | 1 | Transmit data buffer has no free space |
| stat_o | output | 8 | Top status byte (0x00 when empty) |
| tx_cpl_o | output | 1 | Completion pending (store not empty) |
| tx_en_o | output | 1 | Transmitter enabled |
| tx_ovr_o | output | 1 | Sticky transmit overrun flag |
| adapter_fail_o | output | 1 | One-cycle adapter-failure event |

## Verification
The bench fills the store to capacity and then sends one more completion. A design that overwrote an entry, or marked the wrong one, would show the wrong top byte or one pop too many. The bench pops and pushes in the same cycle; a design that let either one win would lose an entry or keep a stale one. It retries enable after a jabber fault and after an underrun fault, where a design without the lock would turn the transmitter back on. It also checks that the failure pulse lasts one cycle, which a level-driven design would hold high. Pops on an empty store and successful frames without the request bit must leave the outputs at zero.

// File: rtl/tx_stat_pkg.sv
package tx_stat_pkg;
  localparam int STAT_W = 8;

  typedef struct packed {
    logic       done;
    logic       req;
    logic       jabber;
    logic       underrun;
    logic       maxcoll;
    logic       ovf;
    logic [1:0] rsvd;
  } stat_byte_t;

  localparam stat_byte_t STAT_EMPTY = '0;
endpackage

// File: rtl/tx_stat_fmt.sv
module tx_stat_fmt
  import tx_stat_pkg::*;
(
  input  logic       valid_i,
  input  logic       req_i,
  input  logic       jabber_i,
  input  logic       underrun_i,
  input  logic       maxcoll_i,
  output logic       push_o,
  output logic       fault_o,
  output stat_byte_t entry_o
);
  logic any_err;

  assign any_err = jabber_i | underrun_i | maxcoll_i;
  // success entries only when requested; errors always recorded
  assign push_o  = valid_i & (any_err | req_i);
  assign fault_o = valid_i & (jabber_i | underrun_i);

  always_comb begin
    entry_o          = STAT_EMPTY;
    entry_o.done     = 1'b1;
    entry_o.req      = req_i;
    entry_o.jabber   = jabber_i;
    entry_o.underrun = underrun_i;
    entry_o.maxcoll  = maxcoll_i;
  end
endmodule

// File: rtl/tx_stat_store.sv
module tx_stat_store
  import tx_stat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic       push_i,
  input  stat_byte_t entry_i,
  input  logic       pop_i,
  output stat_byte_t top_o,
  output logic       nonempty_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  stat_byte_t    mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          full, empty, do_pop, do_push, drop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL);
  assign do_pop  = pop_i & ~empty;
  assign do_push = push_i & (~full | do_pop);
  assign drop    = push_i & full & ~do_pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= STAT_EMPTY;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= entry_i;
        wr_q        <= nxt(wr_q);
      end
      if (drop) mem_q[rd_q].ovf <= 1'b1;
      if (do_pop) rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_o      = empty ? STAT_EMPTY : mem_q[rd_q];
  assign nonempty_o = ~empty;
endmodule

// File: rtl/tx_stat_ctrl.sv
module tx_stat_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_reset_i,
  input  logic tx_enable_i,
  input  logic fault_i,
  input  logic data_wr_i,
  input  logic data_full_i,
  output logic tx_en_o,
  output logic tx_ovr_o,
  output logic fail_o
);
  logic en_q, lock_q, ovr_q, fail_q, ovr_evt;

  assign ovr_evt = data_wr_i & data_full_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      ovr_q  <= 1'b0;
      fail_q <= 1'b0;
    end else if (tx_reset_i) begin
      en_q   <= 1'b0;
      lock_q <= 1'b0;
      ovr_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      fail_q <= ovr_evt & ~ovr_q;
      if (ovr_evt) ovr_q <= 1'b1;
      if (fault_i || ovr_evt) begin
        en_q   <= 1'b0;
        lock_q <= 1'b1;
      end else if (tx_enable_i && !lock_q) begin
        en_q <= 1'b1;
      end
    end
  end

  assign tx_en_o  = en_q;
  assign tx_ovr_o = ovr_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/tx_stat_stack.sv
module tx_stat_stack
  import tx_stat_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpl_valid_i,
  input  logic              cpl_req_i,
  input  logic              cpl_jabber_i,
  input  logic              cpl_underrun_i,
  input  logic              cpl_maxcoll_i,
  input  logic              pop_i,
  input  logic              tx_reset_i,
  input  logic              tx_enable_i,
  input  logic              data_wr_i,
  input  logic              data_full_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              tx_cpl_o,
  output logic              tx_en_o,
  output logic              tx_ovr_o,
  output logic              adapter_fail_o
);
  logic       push, fault;
  stat_byte_t entry, top;

  tx_stat_fmt u_fmt (
    .valid_i   (cpl_valid_i),
    .req_i     (cpl_req_i),
    .jabber_i  (cpl_jabber_i),
    .underrun_i(cpl_underrun_i),
    .maxcoll_i (cpl_maxcoll_i),
    .push_o    (push),
    .fault_o   (fault),
    .entry_o   (entry)
  );

  tx_stat_store #(.DEPTH(DEPTH)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (tx_reset_i),
    .push_i    (push),
    .entry_i   (entry),
    .pop_i     (pop_i),
    .top_o     (top),
    .nonempty_o(tx_cpl_o)
  );

  tx_stat_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_reset_i (tx_reset_i),
    .tx_enable_i(tx_enable_i),
    .fault_i    (fault),
    .data_wr_i  (data_wr_i),
    .data_full_i(data_full_i),
    .tx_en_o    (tx_en_o),
    .tx_ovr_o   (tx_ovr_o),
    .fail_o     (adapter_fail_o)
  );

  assign stat_o = top;
endmodule

// File: rtl/tx_stat_stack_chk.sv
module tx_stat_stack_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpl_valid_i,
  input logic       cpl_req_i,
  input logic       cpl_jabber_i,
  input logic       cpl_underrun_i,
  input logic       cpl_maxcoll_i,
  input logic       pop_i,
  input logic       tx_reset_i,
  input logic       tx_enable_i,
  input logic       data_wr_i,
  input logic       data_full_i,
  input logic [7:0] stat_o,
  input logic       tx_cpl_o,
  input logic       tx_en_o,
  input logic       tx_ovr_o,
  input logic       adapter_fail_o
);
  p_low_bits_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[1:0] == 2'b00);

  p_empty_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_cpl_o |-> stat_o == 8'h00);

  p_pending_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_cpl_o |-> stat_o[7]);

  p_fault_lock_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpl_valid_i && (cpl_jabber_i || cpl_underrun_i) && !tx_reset_i) |=> !tx_en_o);

  p_overrun_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr_i && data_full_i && !tx_reset_i) |=> (tx_ovr_o && !tx_en_o));

  p_fail_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adapter_fail_o |=> !adapter_fail_o);

  p_tx_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_reset_i |=> (!tx_cpl_o && !tx_ovr_o && !tx_en_o));
endmodule

bind tx_stat_stack tx_stat_stack_chk u_chk (.*);

// File: tb/tx_stat_stack_tb.sv
module tx_stat_stack_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cv = 0, cr = 0, cj = 0, cu = 0, cm = 0, pop = 0;
  logic       txr = 0, txe = 0, dwr = 0, dfull = 0;
  logic [7:0] stat;
  logic       cpl, en, ovr, fail;
  int         checks = 0, errors = 0;
  bit         wd_hit = 0;

  always #2.5 clk = ~clk;

  tx_stat_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpl_valid_i(cv), .cpl_req_i(cr), .cpl_jabber_i(cj),
    .cpl_underrun_i(cu), .cpl_maxcoll_i(cm), .pop_i(pop),
    .tx_reset_i(txr), .tx_enable_i(txe),
    .data_wr_i(dwr), .data_full_i(dfull),
    .stat_o(stat), .tx_cpl_o(cpl), .tx_en_o(en),
    .tx_ovr_o(ovr), .adapter_fail_o(fail)
  );

  // {valid, req, jabber, underrun, maxcoll, pop, exp_cpl, exp_stat[7:0]}
  localparam int NV = 9;
  localparam logic [14:0] VEC [NV] = '{
    15'h4000, 15'h61C0, 15'h45C0, 15'h0388, 15'h0200,
    15'h0200, 15'h65C8, 15'h4788, 15'h0200
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cv = 0; cr = 0; cj = 0; cu = 0; cm = 0; pop = 0;
    txr = 0; txe = 0; dwr = 0; dfull = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic complete(input logic r, input logic j, input logic u, input logic m);
    cv = 1; cr = r; cj = j; cu = u; cm = m;
    tick();
  endtask

  initial begin
    #(5 * 200000);
    wd_hit = 1;
  end

  initial begin : main
    fork
      begin : body
        idle();
        #12 rst_n = 1'b1;
        @(posedge clk); #1;
        // R10 reset state
        chk("R10 stat", stat, 8'h00);
        chk("R10 flags", {4'b0, cpl, en, ovr, fail}, 8'h00);

        for (int i = 0; i < NV; i++) begin
          string tag;
          case (i)
            0, 1: tag = "R2";
            2: tag = "R3";
            3, 4, 7: tag = "R4";
            5, 8: tag = "R6";
            default: tag = "R1";
          endcase
          {cv, cr, cj, cu, cm, pop} = VEC[i][14:9];
          tick();
          chk(tag, stat, VEC[i][7:0]);
          chk(tag, {7'b0, cpl}, {7'b0, VEC[i][8]});
        end

        // R5 overflow: fill, then one more
        complete(1, 0, 0, 1);
        for (int k = 0; k < 3; k++) complete(0, 0, 0, 1);
        chk("R5 full top", stat, 8'hC8);
        complete(0, 0, 0, 1);
        chk("R5 ovf top", stat, 8'hCC);
        for (int k = 0; k < 3; k++) begin
          pop = 1; tick();
          chk("R5 remaining", stat, 8'h88);
        end
        pop = 1; tick();
        chk("R5 drained", {7'b0, cpl}, 8'h00);

        // R3 maxcoll alone keeps transmitter on
        txe = 1; tick();
        chk("R3 enabled", {7'b0, en}, 8'h01);
        complete(0, 0, 0, 1);
        chk("R3 still enabled", {7'b0, en}, 8'h01);
        pop = 1; tick();

        // R7 jabber locks
        complete(0, 1, 0, 0);
        chk("R7 jabber entry", stat, 8'hA0);
        chk("R7 disabled", {7'b0, en}, 8'h00);
        txe = 1; tick();
        chk("R7 enable ignored", {7'b0, en}, 8'h00);

        // R9 tx reset recovers
        txr = 1; tick();
        chk("R9 emptied", {6'b0, cpl, en}, 8'h00);
        chk("R9 stat", stat, 8'h00);
        txe = 1; tick();
        chk("R9 re-enable", {7'b0, en}, 8'h01);

        // R7 underrun locks
        complete(1, 0, 1, 0);
        chk("R7 underrun entry", stat, 8'hD0);
        txe = 1; tick();
        chk("R7 underrun lock", {7'b0, en}, 8'h00);
        txr = 1; tick();
        txe = 1; tick();

        // R8 overrun
        dwr = 1; dfull = 0; tick();
        chk("R8 no overrun", {6'b0, ovr, fail}, 8'h00);
        dwr = 1; dfull = 1; tick();
        chk("R8 overrun", {5'b0, ovr, fail, en}, 8'h06);
        dwr = 1; dfull = 1; tick();
        chk("R8 pulse once", {6'b0, ovr, fail}, 8'h02);
        txe = 1; tick();
        chk("R8 locked", {7'b0, en}, 8'h00);
        txr = 1; tick();
        chk("R9 overrun cleared", {6'b0, ovr, en}, 8'h00);
      end
      begin : dog
        wait (wd_hit);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule